// File: doc/BRIEF.md
# Dual-Phase Plesiochronous Cell Retimer

This block carries a stream of cells from a transmit clock into a receive clock that runs at nearly the same rate but comes from a different source. Each cell is either a data cell or an idle cell. The transmit side runs at four times the cell rate and keeps two registered copies of the current cell. The first copy, called Q, is loaded at the start of every cell. The second copy, called R, follows Q by two transmit cycles, which is half a cell. The receive flop always samples one of the two copies, so the data path holds less than one cell of storage and adds well under two cell times of delay.

The transmit side also drives a keep-out flag for each copy. Each flag is high for the two transmit cycles that surround that copy's update. The receive clock samples both flags. The samples go back to the transmit side through a multi-stage synchronizer, which lies outside the data path. There they steer a two-state selector: it moves away from a copy whose keep-out window the receive edge has drifted into.

The selector changes only at the three-quarter point of a cell, when Q and R hold the same cell, and only while that cell is idle. As a result, a drift between the two clocks can repeat or remove only idle cells, never data cells. An optional subrate mode is for a receive clock that runs an integral multiple faster than the cell rate. In this mode the receive side samples once every few cycles and emits idle cells in the other cycles.

Top module: `plesio_retimer`

## Requirements
- R1: While either reset is asserted, the receive outputs show an idle cell with all-zero data and `tx_load` is low. The selector resets to the Q copy.
- R2: `tx_load` is high for exactly one transmit cycle in every four. The input cell is captured at the rising transmit edge that ends that cycle.
- R3: When the receive clock is slower than the cell rate, every data cell sent appears at the output exactly once and in order.
- R4: When the receive clock is faster than the cell rate, every data cell sent appears at the output exactly once and in order.
- R5: The selector changes state only when the cell in Q is idle. With only one cell in sixteen idle, the data sequence still arrives intact.
- R6: The selector changes only at the start of the fourth transmit cycle of a cell (phase 3).
- R7: At phase 3, R holds exactly the cell that Q holds. R is Q delayed by two transmit cycles.
- R8: A data cell reaches the receive outputs no later than 1.6 cell times after the transmit edge that captured it.
- R9: With `RX_DIV` = N > 1, the receive side samples only in one cycle out of N. The output is idle in every other cycle, no two consecutive output cycles carry data, and the data sequence is kept exactly.
- R10: The Q keep-out flag is high during phases 3 and 0. The R keep-out flag is high during phases 1 and 2. The two flags are never high together.
- R11: An input made only of idle cells produces no data cell at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock, four cycles per cell |
| tx_rst_n | input | 1 | Transmit-domain asynchronous reset, active low |
| tx_cell_data | input | CELL_W | Payload of the next cell |
| tx_cell_is_data | input | 1 | 1 = data cell, 0 = idle cell |
| tx_load | output | 1 | High in the cycle whose closing edge captures the input cell |
| rx_clk | input | 1 | Receive clock |
| rx_rst_n | input | 1 | Receive-domain asynchronous reset, active low |
| rx_cell_data | output | CELL_W | Retimed payload |
| rx_cell_is_data | output | 1 | Retimed data flag |

## Verification
Numbered streams are sent with the transmit clock running about 1600 ppm faster than the cell rate, and then about 1600 ppm slower. These two runs tell apart the idle-drop and idle-repeat behaviour of the selector, because the receive edge drifts through both copies' keep-out windows several times in each run. A stream with sparse idle cells shows that switching still finds idle slots when they are rare. An all-idle stream shows that no data is ever made up. A subrate run with the receive clock at twice the cell rate separates sampled cycles from filler cycles. Latency is measured per cell against the capture edge.

// File: rtl/plesio_retimer.sv
module plesio_retimer #(
  parameter int CELL_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RX_DIV      = 1
) (
  input  logic              tx_clk,
  input  logic              tx_rst_n,
  input  logic [CELL_W-1:0] tx_cell_data,
  input  logic              tx_cell_is_data,
  output logic              tx_load,
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  output logic [CELL_W-1:0] rx_cell_data,
  output logic              rx_cell_is_data
);
  timeunit 1ps;
  timeprecision 1ps;

  localparam int DIV_W = (RX_DIV > 1) ? $clog2(RX_DIV) : 1;
  localparam logic [1:0] PH_QLOAD  = 2'd3;
  localparam logic [1:0] PH_RLOAD  = 2'd1;
  localparam logic [1:0] PH_DECIDE = 2'd2;

  logic [1:0]        ph;
  logic [CELL_W-1:0] q_data, r_data;
  logic              q_is, r_is;
  logic              q_ko, r_ko;
  logic              sel;
  logic [SYNC_STAGES-1:0] qko_sync, rko_sync;
  logic              rx_qko, rx_rko;
  logic              rx_en;
  logic [CELL_W-1:0] pick_data;
  logic              pick_is;

  assign tx_load = (ph == PH_QLOAD);

  always_ff @(posedge tx_clk or negedge tx_rst_n)
    if (!tx_rst_n) ph <= 2'd0;
    else           ph <= ph + 2'd1;

  always_ff @(posedge tx_clk or negedge tx_rst_n)
    if (!tx_rst_n) begin
      q_data <= '0;
      q_is   <= 1'b0;
    end else if (ph == PH_QLOAD) begin
      q_data <= tx_cell_data;
      q_is   <= tx_cell_is_data;
    end

  always_ff @(posedge tx_clk or negedge tx_rst_n)
    if (!tx_rst_n) begin
      r_data <= '0;
      r_is   <= 1'b0;
    end else if (ph == PH_RLOAD) begin
      r_data <= q_data;
      r_is   <= q_is;
    end

  always_ff @(posedge tx_clk or negedge tx_rst_n)
    if (!tx_rst_n) begin
      q_ko <= 1'b1;
      r_ko <= 1'b0;
    end else begin
      q_ko <= (ph == 2'd2) || (ph == 2'd3);
      r_ko <= (ph == 2'd0) || (ph == 2'd1);
    end

  always_ff @(posedge tx_clk or negedge tx_rst_n)
    if (!tx_rst_n) begin
      qko_sync <= '0;
      rko_sync <= '0;
    end else begin
      qko_sync[0] <= rx_qko;
      rko_sync[0] <= rx_rko;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        qko_sync[i] <= qko_sync[i-1];
        rko_sync[i] <= rko_sync[i-1];
      end
    end

  always_ff @(posedge tx_clk or negedge tx_rst_n)
    if (!tx_rst_n) sel <= 1'b0;
    else if (ph == PH_DECIDE && !q_is) begin
      if (!sel && qko_sync[SYNC_STAGES-1])     sel <= 1'b1;
      else if (sel && rko_sync[SYNC_STAGES-1]) sel <= 1'b0;
    end

  assign pick_data = sel ? r_data : q_data;
  assign pick_is   = sel ? r_is   : q_is;

  generate
    if (RX_DIV > 1) begin : g_subrate
      logic [DIV_W-1:0] rx_cnt;
      always_ff @(posedge rx_clk or negedge rx_rst_n)
        if (!rx_rst_n)                          rx_cnt <= '0;
        else if (rx_cnt == DIV_W'(RX_DIV - 1))  rx_cnt <= '0;
        else                                    rx_cnt <= rx_cnt + DIV_W'(1);
      assign rx_en = (rx_cnt == '0);
    end else begin : g_fullrate
      assign rx_en = 1'b1;
    end
  endgenerate

  always_ff @(posedge rx_clk or negedge rx_rst_n)
    if (!rx_rst_n) begin
      rx_qko          <= 1'b0;
      rx_rko          <= 1'b0;
      rx_cell_data    <= '0;
      rx_cell_is_data <= 1'b0;
    end else if (rx_en) begin
      rx_qko          <= q_ko;
      rx_rko          <= r_ko;
      rx_cell_data    <= pick_data;
      rx_cell_is_data <= pick_is;
    end else begin
      rx_cell_data    <= '0;
      rx_cell_is_data <= 1'b0;
    end
endmodule

// File: rtl/plesio_retimer_chk.sv
module plesio_retimer_chk #(
  parameter int CELL_W = 16
) (
  input logic              tx_clk,
  input logic              tx_rst_n,
  input logic              rx_clk,
  input logic              rx_rst_n,
  input logic [1:0]        ph,
  input logic              sel,
  input logic [CELL_W-1:0] q_data,
  input logic              q_is,
  input logic [CELL_W-1:0] r_data,
  input logic              r_is,
  input logic              q_ko,
  input logic              r_ko,
  input logic              rx_en,
  input logic              rx_cell_is_data
);
  timeunit 1ps;
  timeprecision 1ps;

  assert_switch_idle_R5: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (sel != $past(sel)) |-> !q_is);

  assert_switch_phase_R6: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (sel != $past(sel)) |-> (ph == 2'd3));

  assert_r_follows_q_R7: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (ph == 2'd3) |-> (r_data == q_data && r_is == q_is));

  assert_q_keepout_R10: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    q_ko == (ph == 2'd3 || ph == 2'd0));

  assert_keepout_disjoint_R10: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    $onehot0({q_ko, r_ko}) && (q_ko || r_ko));

  assert_subrate_filler_R9: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    !rx_en |=> !rx_cell_is_data);
endmodule

bind plesio_retimer plesio_retimer_chk #(.CELL_W(CELL_W)) u_chk (
  .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
  .ph(ph), .sel(sel), .q_data(q_data), .q_is(q_is), .r_data(r_data), .r_is(r_is),
  .q_ko(q_ko), .r_ko(r_ko), .rx_en(rx_en), .rx_cell_is_data(rx_cell_is_data)
);

// File: tb/plesio_retimer_bench.sv
module plesio_retimer_bench;
  timeunit 1ps;
  timeprecision 1ps;

  localparam int W = 16;
  localparam int RX_HALF = 10000;

  logic tx_clk, tx_clk_s, rx_clk, tx_rst_n, rx_rst_n;
  logic [W-1:0] tx_data, tx_data_s, rx_data, rx_data_s;
  logic tx_isd, tx_isd_s, rx_isd, rx_isd_s, tx_load, tx_load_s;
  int tx_p;

  int tests, fails, wd;
  bit drv_on, mon_on, drv_s_on, mon_s_on;
  int idle_every, k_tx, seq_tx, k_s, seq_s;
  int exp_seq, mism, rcvd, exp_s, mism_s, rcvd_s, b2b_s;
  bit prev_s;
  longint cap_t [256];
  longint lat, max_lat;

  plesio_retimer #(.CELL_W(W), .SYNC_STAGES(2), .RX_DIV(1)) u_plesio_retimer (
    .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_cell_data(tx_data), .tx_cell_is_data(tx_isd),
    .tx_load(tx_load), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
    .rx_cell_data(rx_data), .rx_cell_is_data(rx_isd));

  plesio_retimer #(.CELL_W(W), .SYNC_STAGES(2), .RX_DIV(2)) u_plesio_retimer_sub (
    .tx_clk(tx_clk_s), .tx_rst_n(tx_rst_n), .tx_cell_data(tx_data_s), .tx_cell_is_data(tx_isd_s),
    .tx_load(tx_load_s), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
    .rx_cell_data(rx_data_s), .rx_cell_is_data(rx_isd_s));

  initial begin
    rx_clk = 1'b0;
    #1;
    forever #RX_HALF rx_clk = ~rx_clk;
  end

  initial begin
    tx_clk = 1'b0;
    forever begin
      #(tx_p / 2) tx_clk = 1'b1;
      #(tx_p / 2) tx_clk = 1'b0;
    end
  end

  initial begin
    tx_clk_s = 1'b0;
    forever #5008 tx_clk_s = ~tx_clk_s;
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    wd = 0;
    forever begin
      @(posedge rx_clk);
      wd++;
      if (wd > 180000) begin
        tests++; fails++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", wd, 180000);
        summary();
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  initial begin
    forever begin
      @(negedge tx_clk);
      if (tx_load) begin
        if (!drv_on) begin
          tx_isd = 1'b0; tx_data = '0;
        end else begin
          k_tx++;
          if (k_tx % idle_every == 0) begin
            tx_isd = 1'b0; tx_data = '0;
          end else begin
            tx_isd = 1'b1; tx_data = W'(seq_tx);
            cap_t[seq_tx % 256] = $time + tx_p / 2;
            seq_tx++;
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge tx_clk_s);
      if (tx_load_s) begin
        if (!drv_s_on) begin
          tx_isd_s = 1'b0; tx_data_s = '0;
        end else begin
          k_s++;
          if (k_s % 4 == 0) begin
            tx_isd_s = 1'b0; tx_data_s = '0;
          end else begin
            tx_isd_s = 1'b1; tx_data_s = W'(seq_s);
            seq_s++;
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge rx_clk);
      if (mon_on && rx_isd) begin
        if (int'(rx_data) != exp_seq) mism++;
        lat = $time - RX_HALF - cap_t[int'(rx_data) % 256];
        if (lat > max_lat) max_lat = lat;
        exp_seq = int'(rx_data) + 1;
        rcvd++;
      end
      if (mon_s_on) begin
        if (rx_isd_s) begin
          if (int'(rx_data_s) != exp_s) mism_s++;
          if (prev_s) b2b_s++;
          exp_s = int'(rx_data_s) + 1;
          rcvd_s++;
        end
        prev_s = rx_isd_s;
      end
    end
  end

  task automatic do_reset();
    @(negedge rx_clk);
    tx_rst_n = 1'b0; rx_rst_n = 1'b0;
    drv_on = 0; drv_s_on = 0; mon_on = 0; mon_s_on = 0;
    k_tx = 0; seq_tx = 0; k_s = 0; seq_s = 0;
    repeat (4) @(negedge rx_clk);
    chk(rx_isd == 1'b0 && rx_isd_s == 1'b0, "R1 idle flag in reset", rx_isd, 0);
    chk(rx_data == '0, "R1 data in reset", rx_data, 0);
    chk(tx_load == 1'b0, "R1 tx_load in reset", tx_load, 0);
    tx_rst_n = 1'b1; rx_rst_n = 1'b1;
  endtask

  task automatic t_load_cadence();
    int highs, gap_bad, last;
    highs = 0; gap_bad = 0; last = -1;
    tx_p = 5008;
    do_reset();
    for (int i = 0; i < 40; i++) begin
      @(negedge tx_clk);
      if (tx_load) begin
        if (last >= 0 && i - last != 4) gap_bad++;
        last = i; highs++;
      end
    end
    chk(highs == 10, "R2 tx_load count", highs, 10);
    chk(gap_bad == 0, "R2 tx_load spacing", gap_bad, 0);
  endtask

  task automatic t_stream(input int p, input int ie, input int n, input string tag);
    tx_p = p;
    do_reset();
    idle_every = ie;
    repeat (64 * 4) @(posedge tx_clk);
    exp_seq = 0; mism = 0; rcvd = 0; max_lat = 0;
    mon_on = 1;
    drv_on = 1;
    repeat (n * 4) @(posedge tx_clk);
    drv_on = 0;
    repeat (40 * 4) @(posedge tx_clk);
    mon_on = 0;
    chk(mism == 0, {tag, " order"}, mism, 0);
    chk(rcvd == seq_tx, {tag, " count"}, rcvd, seq_tx);
    chk(max_lat <= longint'(16 * 4 * p / 10), "R8 latency", max_lat, 16 * 4 * p / 10);
  endtask

  task automatic t_all_idle();
    tx_p = 5008;
    do_reset();
    rcvd = 0; exp_seq = 0; mism = 0; max_lat = 0;
    mon_on = 1;
    repeat (2000) @(posedge rx_clk);
    mon_on = 0;
    chk(rcvd == 0, "R11 idle-only input", rcvd, 0);
  endtask

  task automatic t_subrate();
    do_reset();
    repeat (64 * 4) @(posedge tx_clk_s);
    exp_s = 0; mism_s = 0; rcvd_s = 0; b2b_s = 0; prev_s = 0;
    mon_s_on = 1;
    drv_s_on = 1;
    repeat (1500 * 4) @(posedge tx_clk_s);
    drv_s_on = 0;
    repeat (40 * 4) @(posedge tx_clk_s);
    mon_s_on = 0;
    chk(mism_s == 0, "R9 order", mism_s, 0);
    chk(rcvd_s == seq_s, "R9 count", rcvd_s, seq_s);
    chk(b2b_s == 0, "R9 filler cycles", b2b_s, 0);
  endtask

  initial begin
    tests = 0; fails = 0;
    tx_p = 5008;
    tx_rst_n = 1'b0; rx_rst_n = 1'b0;
    tx_data = '0; tx_isd = 1'b0; tx_data_s = '0; tx_isd_s = 1'b0;
    idle_every = 4;
    t_load_cadence();
    t_stream(4992, 4, 3000, "R3");
    t_stream(5008, 4, 3000, "R4");
    t_stream(5008, 16, 3000, "R5");
    t_all_idle();
    t_subrate();
    summary();
  end
endmodule